// File: doc/BRIEF.md
# Set-Associative Cache Miss Classifier

This block is a tag-only model of a very small two-way set-associative cache that uses least-recently-used replacement. It takes one byte address per accepted transfer. One cycle later it reports whether the access hit. When the access misses, it also reports whether the miss was compulsory, capacity or conflict. The block holds no data. It keeps three structures side by side:

- the set-associative tag store;
- a record of which blocks have been referenced since reset;
- a fully-associative shadow tag store with the same number of lines, also replaced least recently used.

The shadow store and the reference record are what allow a miss to be classified.

Both edges of the block are valid/ready streams. An address is taken only when `in_valid` and `in_ready` are both high at a rising edge. `in_ready` is high whenever the result register is empty, or when it is being drained in that same cycle. While `out_valid` is high and `out_ready` is low, the result holds steady, and so do all cache contents. The per-set tag view is driven directly from the tag store. After each access it shows every way of every set, with the most recently used way first.

Top module: `cm_classifier`

## Requirements
- R1: While synchronous reset is high, and at the first cycle after it, every valid bit in the tag view is 0, `out_valid` is 0 and `in_ready` is 1.
- R2: Address bit 0 is the byte offset, bit 1 selects the set and bits 3:2 are the tag. Two addresses that differ only in bit 0 name the same block, so an access to one hits when the other was accessed just before.
- R3: The tag view for set s, way w sits at `set_tags[(s*2+w)*2 +: 2]`, with its valid bit at `set_vld[s*2+w]`. Way 0 is the most recently used. A hit moves its tag to way 0. A miss puts the new tag in way 0 and moves the old way 0 to way 1, which drops the least recently used tag.
- R4: A hit gives `out_hit`=1 and `out_miss_type`=00.
- R5: A miss on a block not referenced since reset gives `out_miss_type`=01 (compulsory).
- R6: A miss on a block referenced before gives `out_miss_type`=11 (conflict) if the four-line fully-associative shadow cache holds that block. The shadow cache is updated on every access.
- R7: A miss on a block referenced before gives `out_miss_type`=10 (capacity) if the shadow cache does not hold it either.
- R8: The result of an accepted address appears with `out_valid`=1 on the edge after acceptance. With `out_ready`=1 and no new address, `out_valid` falls one cycle later.
- R9: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0. Offered addresses are not taken, and the result and tag view stay unchanged. When `out_ready` rises, the held result drains and a waiting address is accepted on the same edge.
- R10: Reset also clears the reference history, so after reset a block used earlier again gives a compulsory miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Address offered |
| in_ready | output | 1 | Block can take an address this cycle |
| in_addr | input | 4 | Byte address |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_hit | output | 1 | Access hit |
| out_miss_type | output | 2 | 00 hit, 01 compulsory, 10 capacity, 11 conflict |
| set_tags | output | 8 | Tags per set and way, most recent way first |
| set_vld | output | 4 | Valid bit per set and way |

## Verification
Two things can meet in one cycle: a result stalled by the consumer, and a fresh address waiting at the input. The bench sets `out_ready` low while an address is offered, and checks that the held result, the tag view and `in_ready` stay frozen. It then raises `out_ready` and checks that the waiting address was taken exactly once on the edge that drained the old result. It judges this by the second access reporting a hit on the block the first one filled. The full eleven-address sequence is also run against a behavioural model in the bench, and it produces all four result codes.

// File: rtl/cm_pkg.sv
package cm_pkg;
  typedef enum logic [1:0] {
    MT_HIT  = 2'b00,
    MT_COMP = 2'b01,
    MT_CAP  = 2'b10,
    MT_CONF = 2'b11
  } miss_kind_e;
endpackage

// File: rtl/cm_lru_stack.sv
// Ordered tag stack: entry 0 is most recent, last entry is the victim.
module cm_lru_stack #(
  parameter int DEPTH = 2,
  parameter int KEY_W = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   upd,
  input  logic [KEY_W-1:0]       key,
  output logic                   hit,
  output logic [DEPTH*KEY_W-1:0] keys_o,
  output logic [DEPTH-1:0]       vld_o
);
  logic [KEY_W-1:0] k_q [DEPTH];
  logic [DEPTH-1:0] v_q;
  logic [DEPTH-1:0] match;
  int               pos;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign match[i] = v_q[i] && (k_q[i] == key);
    assign keys_o[i*KEY_W +: KEY_W] = k_q[i];
  end

  assign vld_o = v_q;
  assign hit   = |match;

  // position that gets refilled from above; a miss shifts the whole stack
  always_comb begin
    pos = DEPTH - 1;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) pos = i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0;
    end else if (upd) begin
      for (int i = DEPTH - 1; i > 0; i--) begin
        if (i <= pos) begin
          k_q[i] <= k_q[i-1];
          v_q[i] <= v_q[i-1];
        end
      end
      k_q[0] <= key;
      v_q[0] <= 1'b1;
    end
  end
endmodule

// File: rtl/cm_first_touch.sv
module cm_first_touch #(
  parameter int IDX_W  = 3,
  parameter int BLOCKS = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [IDX_W-1:0] idx,
  output logic             seen
);
  logic [BLOCKS-1:0] ref_q;

  assign seen = ref_q[idx];

  always_ff @(posedge clk) begin
    if (rst)      ref_q      <= '0;
    else if (upd) ref_q[idx] <= 1'b1;
  end
endmodule

// File: rtl/cm_classify.sv
module cm_classify
  import cm_pkg::*;
(
  input  logic       main_hit,
  input  logic       seen,
  input  logic       shadow_hit,
  output miss_kind_e kind
);
  always_comb begin
    if (main_hit)        kind = MT_HIT;
    else if (!seen)      kind = MT_COMP;
    else if (shadow_hit) kind = MT_CONF;
    else                 kind = MT_CAP;
  end
endmodule

// File: rtl/cm_classifier.sv
module cm_classifier
  import cm_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int OFFSET_W = 1,
  parameter int SET_W    = 1,
  parameter int WAYS     = 2
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                in_valid,
  output logic                                in_ready,
  input  logic [ADDR_W-1:0]                   in_addr,
  output logic                                out_valid,
  input  logic                                out_ready,
  output logic                                out_hit,
  output logic [1:0]                          out_miss_type,
  output logic [(1<<SET_W)*WAYS*(ADDR_W-OFFSET_W-SET_W)-1:0] set_tags,
  output logic [(1<<SET_W)*WAYS-1:0]          set_vld
);
  localparam int BLK_W  = ADDR_W - OFFSET_W;
  localparam int TAG_W  = BLK_W - SET_W;
  localparam int SETS   = 1 << SET_W;
  localparam int LINES  = SETS * WAYS;

  logic              acc;
  logic [BLK_W-1:0]  blk;
  logic [SET_W-1:0]  set_idx;
  logic [TAG_W-1:0]  tag;
  logic [SETS-1:0]   set_hit;
  logic              main_hit;
  logic              seen;
  logic              shadow_hit;
  logic [LINES*BLK_W-1:0] shadow_keys;
  logic [LINES-1:0]  shadow_vld;
  logic              offset_unused;
  miss_kind_e        kind;
  miss_kind_e        type_q;
  logic              hit_q;
  logic              valid_q;

  assign in_ready      = !valid_q || out_ready;
  assign acc           = in_valid && in_ready;
  assign blk           = in_addr[ADDR_W-1:OFFSET_W];
  assign set_idx       = blk[SET_W-1:0];
  assign tag           = blk[BLK_W-1:SET_W];
  assign offset_unused = ^in_addr[OFFSET_W-1:0];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    cm_lru_stack #(.DEPTH(WAYS), .KEY_W(TAG_W)) u_set (
      .clk    (clk),
      .rst    (rst),
      .upd    (acc && (set_idx == SET_W'(s))),
      .key    (tag),
      .hit    (set_hit[s]),
      .keys_o (set_tags[s*WAYS*TAG_W +: WAYS*TAG_W]),
      .vld_o  (set_vld[s*WAYS +: WAYS])
    );
  end

  assign main_hit = set_hit[set_idx];

  cm_lru_stack #(.DEPTH(LINES), .KEY_W(BLK_W)) u_shadow (
    .clk    (clk),
    .rst    (rst),
    .upd    (acc),
    .key    (blk),
    .hit    (shadow_hit),
    .keys_o (shadow_keys),
    .vld_o  (shadow_vld)
  );

  cm_first_touch #(.IDX_W(BLK_W)) u_touch (
    .clk  (clk),
    .rst  (rst),
    .upd  (acc),
    .idx  (blk),
    .seen (seen)
  );

  cm_classify u_cls (
    .main_hit   (main_hit),
    .seen       (seen),
    .shadow_hit (shadow_hit),
    .kind       (kind)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      hit_q   <= 1'b0;
      type_q  <= MT_HIT;
    end else if (acc) begin
      valid_q <= 1'b1;
      hit_q   <= main_hit;
      type_q  <= kind;
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid     = valid_q;
  assign out_hit       = hit_q;
  assign out_miss_type = type_q;
endmodule

// File: rtl/cm_classifier_chk.sv
module cm_classifier_chk #(
  parameter int ADDR_W   = 4,
  parameter int OFFSET_W = 1,
  parameter int SETS     = 2,
  parameter int WAYS     = 2,
  parameter int TAG_W    = 2,
  parameter int BLK_W    = 3,
  parameter int LINES    = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic [ADDR_W-1:0]      in_addr,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic                   out_hit,
  input logic [1:0]             out_miss_type,
  input logic [SETS*WAYS*TAG_W-1:0] set_tags,
  input logic [SETS*WAYS-1:0]   set_vld,
  input logic [LINES*BLK_W-1:0] shadow_keys,
  input logic [LINES-1:0]       shadow_vld
);
  a_r8_result_next: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_hit) &&
      $stable(out_miss_type) && $stable(set_tags) && $stable(set_vld)));

  a_r4_hit_code: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_hit == (out_miss_type == 2'b00)));

  a_r2_same_block: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && in_valid && in_ready && $past(in_valid && in_ready) &&
     (in_addr[ADDR_W-1:OFFSET_W] == $past(in_addr[ADDR_W-1:OFFSET_W])))
    |=> out_hit);

  a_r6_shadow_covers: assert property (@(posedge clk) disable iff (rst)
    $countones(set_vld) <= $countones(shadow_vld));

  for (genvar s = 0; s < SETS; s++) begin : g_s
    for (genvar w = 0; w + 1 < WAYS; w++) begin : g_w
      a_r3_fill_order: assert property (@(posedge clk) disable iff (rst)
        set_vld[s*WAYS+w+1] |-> set_vld[s*WAYS+w]);
      a_r3_unique_tag: assert property (@(posedge clk) disable iff (rst)
        (set_vld[s*WAYS+w+1] && set_vld[s*WAYS+w]) |->
        (set_tags[(s*WAYS+w)*TAG_W +: TAG_W] != set_tags[(s*WAYS+w+1)*TAG_W +: TAG_W]));
    end
  end

  for (genvar i = 0; i + 1 < LINES; i++) begin : g_l
    a_r6_shadow_order: assert property (@(posedge clk) disable iff (rst)
      shadow_vld[i+1] |-> shadow_vld[i]);
    a_r6_shadow_unique: assert property (@(posedge clk) disable iff (rst)
      (shadow_vld[i+1] && shadow_vld[i]) |->
      (shadow_keys[i*BLK_W +: BLK_W] != shadow_keys[(i+1)*BLK_W +: BLK_W]));
  end
endmodule

bind cm_classifier cm_classifier_chk #(
  .ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .SETS(SETS), .WAYS(WAYS),
  .TAG_W(TAG_W), .BLK_W(BLK_W), .LINES(LINES)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
  .out_hit(out_hit), .out_miss_type(out_miss_type), .set_tags(set_tags),
  .set_vld(set_vld), .shadow_keys(shadow_keys), .shadow_vld(shadow_vld)
);

// File: tb/sim_cm_classifier.sv
module sim_cm_classifier;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] in_addr = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic       out_hit;
  logic [1:0] out_miss_type;
  logic [7:0] set_tags;
  logic [3:0] set_vld;

  int checks = 0;
  int errors = 0;

  // behavioural model
  logic [1:0] rt [2][2];
  logic       rv [2][2];
  logic [2:0] fa [4];
  logic       fv [4];
  logic       seen [8];

  always #(CLK_P/2) clk = ~clk;

  cm_classifier u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
    .out_hit(out_hit), .out_miss_type(out_miss_type),
    .set_tags(set_tags), .set_vld(set_vld)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < 2; s++) for (int w = 0; w < 2; w++) begin
      rv[s][w] = 1'b0; rt[s][w] = '0;
    end
    for (int i = 0; i < 4; i++) begin fv[i] = 1'b0; fa[i] = '0; end
    for (int i = 0; i < 8; i++) seen[i] = 1'b0;
  endtask

  task automatic model_access(input logic [3:0] a, output int h, output int mt);
    logic [2:0] b;
    int s;
    logic [1:0] t;
    int fh;
    int p;
    b = a[3:1]; s = int'(b[0]); t = b[2:1];
    h = ((rv[s][0] && rt[s][0] == t) || (rv[s][1] && rt[s][1] == t)) ? 1 : 0;
    fh = 0; p = 3;
    for (int i = 3; i >= 0; i--) if (fv[i] && fa[i] == b) begin fh = 1; p = i; end
    if (h == 1) mt = 0;
    else if (!seen[b]) mt = 1;
    else if (fh == 1) mt = 3;
    else mt = 2;
    seen[b] = 1'b1;
    if (!(rv[s][0] && rt[s][0] == t)) begin
      rt[s][1] = rt[s][0]; rv[s][1] = rv[s][0];
      rt[s][0] = t; rv[s][0] = 1'b1;
    end
    for (int i = 3; i > 0; i--) if (i <= p) begin fa[i] = fa[i-1]; fv[i] = fv[i-1]; end
    fa[0] = b; fv[0] = 1'b1;
  endtask

  task automatic check_view(input string tagline);
    for (int s = 0; s < 2; s++) for (int w = 0; w < 2; w++) begin
      chk("R3", {tagline, " valid"}, int'(set_vld[s*2+w]), int'(rv[s][w]));
      if (rv[s][w]) chk("R3", {tagline, " tag"}, int'(set_tags[(s*2+w)*2 +: 2]), int'(rt[s][w]));
    end
  endtask

  function automatic string type_req(input int mt);
    case (mt)
      0: return "R4";
      1: return "R5";
      2: return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  task automatic access(input logic [3:0] a, output int h, output int mt);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
    model_access(a, h, mt);
    chk("R8", "out_valid after accept", int'(out_valid), 1);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1", "out_valid", int'(out_valid), 0);
    chk("R1", "in_ready", int'(in_ready), 1);
    chk("R1", "set_vld", int'(set_vld), 0);
  endtask

  task automatic t_replay();
    logic [3:0] seq [11];
    int hard [11];
    int h, mt;
    seq = '{4'b0110, 4'b0000, 4'b0010, 4'b0001, 4'b0011, 4'b0100,
            4'b1001, 4'b0000, 4'b1010, 4'b1111, 4'b0111};
    hard = '{1, 1, 1, 0, 0, 1, 1, 3, 1, 1, 2};
    do_reset();
    for (int k = 0; k < 11; k++) begin
      access(seq[k], h, mt);
      chk(type_req(mt), "hit", int'(out_hit), h);
      chk(type_req(mt), "miss_type", int'(out_miss_type), mt);
      chk(type_req(hard[k]), "miss_type fixed", int'(out_miss_type), hard[k]);
      check_view("replay");
    end
    // offset alias: 0001 right after 0000-block fill hits (index 3)
    chk("R2", "alias hit count", hard[3], 0);
  endtask

  task automatic t_stall();
    int h, mt;
    do_reset();
    out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_addr = 4'b0000;
    @(negedge clk);
    model_access(4'b0000, h, mt);
    chk("R5", "first result", int'(out_miss_type), 1);
    chk("R9", "in_ready stalled", int'(in_ready), 0);
    in_addr = 4'b0001;
    @(negedge clk);
    chk("R9", "out_valid held", int'(out_valid), 1);
    chk("R9", "type held", int'(out_miss_type), 1);
    check_view("stall");
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    model_access(4'b0001, h, mt);
    chk("R9", "second out_valid", int'(out_valid), 1);
    chk("R9", "second hit", int'(out_hit), 1);
    chk("R2", "second type", int'(out_miss_type), 0);
    check_view("release");
    @(negedge clk);
    chk("R8", "out_valid drops", int'(out_valid), 0);
  endtask

  task automatic t_reset_history();
    int h, mt;
    do_reset();
    chk("R1", "set_vld after reset", int'(set_vld), 0);
    access(4'b0110, h, mt);
    chk("R10", "block again compulsory", int'(out_miss_type), 1);
    access(4'b0111, h, mt);
    chk("R4", "repeat hit", int'(out_hit), 1);
    access(4'b0000, h, mt);
    chk("R10", "second block compulsory", int'(out_miss_type), 1);
    check_view("after reset");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_clear();
    t_reset_state();
    t_replay();
    t_stall();
    t_reset_history();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule